// File: doc/BRIEF.md
# Broadcast-Driven Pattern Playback Slave

This block feeds one analog channel, such as a clock driver or a video filter stage, with a 12-bit word on every cycle of a 100 MHz clock. The words come from a pattern table held inside the slave. A central sequencer never streams pattern data. It broadcasts only a clock enable, a start strobe and an 8-bit code that names the next waveform type. Every slave on the bus sees the same broadcast.

A start strobe makes the pending code the active waveform and sets the offset within that waveform to zero. A per-type base register gives the first table address of each waveform type. The table address on each cycle is that base plus the running offset. A type-enable mask selects which waveform types this slave answers. When the active type is masked off, the output word stays frozen and the offset does not advance. The offset only moves on cycles with the clock enable high, so a prescaled slow waveform holds each word for several clocks.

The table, the base registers and the mask are loaded through one write port. That port is locked while the readout-running input is high.

Top module: `pattern_slave`

## Requirements
- R1: After reset `dataOut` is 0, and it stays 0 until the first start strobe has been followed by a clock edge with an enabled active type.
- R2: At the clock edge where `startStb` is high, `nextCode` becomes the active type and the offset becomes 0. The word read from table address `base[code]` appears on `dataOut` after the next edge, provided that type is enabled.
- R3: While the active type is enabled and no start strobe is present, each edge with `clkEn` high advances the offset by one. `dataOut` shows the word at the pre-edge address after every edge.
- R4: An edge with `clkEn` low and no start strobe leaves the offset unchanged, so the same word is repeated.
- R5: The table address is `base[code] + offset` taken modulo the table depth (1024 by default). Playback wraps from the last address to address 0.
- R6: While the active type has its mask bit clear, `dataOut` holds its last value and the offset does not advance. After the bit is set, playback resumes from the held offset.
- R7: The write port stores `cfgData` at an edge with `cfgWrEn` high only when `runActive` is low. `cfgKind` selects the target: 0 writes table entry `cfgAddr`; 1 writes the base register of type `cfgAddr[7:0]` with `cfgData[9:0]`; 2 writes the mask bit of type `cfgAddr[7:0]` with `cfgData[0]`; 3 writes nothing.
- R8: When a start strobe and a high `clkEn` fall on the same edge, the start wins and the offset becomes 0, not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz pattern clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Broadcast clock enable; permits offset advance |
| startStb | input | 1 | Broadcast start of next waveform |
| nextCode | input | 8 | Broadcast code of the next waveform type |
| runActive | input | 1 | High while a readout runs; locks the write port |
| cfgWrEn | input | 1 | Write strobe of the configuration port |
| cfgKind | input | 2 | Write target: 0 table, 1 base, 2 mask, 3 none |
| cfgAddr | input | 10 | Table address, or type code in the low 8 bits |
| cfgData | input | 12 | Write data |
| dataOut | output | 12 | Pattern word toward the DAC or filter |

## Verification
Two functions can act on the same edge. A start strobe reloads the offset, and the clock enable tries to advance it. The case is provoked by asserting both while a waveform is already partway through, and it passes only if the next word comes from offset 0. A second collision is a mask write that lands while a disabled type is active. The bench checks that the word played on that edge still follows the old mask, and that playback resumes from the frozen offset on the following edge. Constrained-random runs mix strobes, enables and configuration writes so that these coincidences recur, and a cycle model built from the requirements judges each cycle.

// File: rtl/pattern_slave_pkg.sv
package pattern_slave_pkg;
  localparam logic [1:0] KIND_TABLE = 2'd0;
  localparam logic [1:0] KIND_BASE  = 2'd1;
  localparam logic [1:0] KIND_MASK  = 2'd2;

  typedef struct packed {
    logic tblWr;
    logic baseWr;
    logic maskWr;
    logic play;
  } ctrlStb_t;
endpackage

// File: rtl/pattern_slave_ctrl.sv
module pattern_slave_ctrl
  import pattern_slave_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              startStb,
  input  logic [CODE_W-1:0] nextCode,
  input  logic              runActive,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic              typeOn,
  output ctrlStb_t          stb,
  output logic [CODE_W-1:0] curCode,
  output logic [ADDR_W-1:0] curOffset,
  output logic              started
);
  logic writeOk;

  always_comb begin
    writeOk    = cfgWrEn && !runActive;
    stb.tblWr  = writeOk && (cfgKind == KIND_TABLE);
    stb.baseWr = writeOk && (cfgKind == KIND_BASE);
    stb.maskWr = writeOk && (cfgKind == KIND_MASK);
    stb.play   = started && typeOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCode   <= '0;
      curOffset <= '0;
      started   <= 1'b0;
    end else if (startStb) begin
      curCode   <= nextCode;
      curOffset <= '0;
      started   <= 1'b1;
    end else if (started && typeOn && clkEn) begin
      curOffset <= curOffset + 1'b1;
    end
  end
endmodule

// File: rtl/pattern_slave_dp.sv
module pattern_slave_dp
  import pattern_slave_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 10,
  parameter int CODE_W = 8,
  parameter int CFG_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [CODE_W-1:0] curCode,
  input  logic [ADDR_W-1:0] curOffset,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output logic              typeOn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TYPES = 1 << CODE_W;

  logic [DATA_W-1:0] patMem [DEPTH];
  logic [ADDR_W-1:0] baseReg [TYPES];
  logic [TYPES-1:0]  typeMask;
  logic [ADDR_W-1:0] readAddr;
  logic [CODE_W-1:0] cfgType;

  assign cfgType  = cfgAddr[CODE_W-1:0];
  assign readAddr = baseReg[curCode] + curOffset;
  assign typeOn   = typeMask[curCode];

  always_ff @(posedge clk) begin
    if (stb.tblWr) patMem[cfgAddr] <= cfgData[DATA_W-1:0];
  end

  for (genvar t = 0; t < TYPES; t++) begin : g_type
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseReg[t]  <= '0;
        typeMask[t] <= 1'b0;
      end else if (cfgType == CODE_W'(t)) begin
        if (stb.baseWr) baseReg[t]  <= cfgData[ADDR_W-1:0];
        if (stb.maskWr) typeMask[t] <= cfgData[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         dataOut <= '0;
    else if (stb.play) dataOut <= patMem[readAddr];
  end
endmodule

// File: rtl/pattern_slave.sv
module pattern_slave
  import pattern_slave_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 10,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              startStb,
  input  logic [CODE_W-1:0] nextCode,
  input  logic              runActive,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgKind,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  output logic [DATA_W-1:0] dataOut
);
  ctrlStb_t          stb;
  logic [CODE_W-1:0] curCode;
  logic [ADDR_W-1:0] curOffset;
  logic              started;
  logic              typeOn;

  pattern_slave_ctrl #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .startStb(startStb),
    .nextCode(nextCode), .runActive(runActive), .cfgWrEn(cfgWrEn),
    .cfgKind(cfgKind), .typeOn(typeOn), .stb(stb), .curCode(curCode),
    .curOffset(curOffset), .started(started)
  );

  pattern_slave_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
                     .CFG_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .curCode(curCode),
    .curOffset(curOffset), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .typeOn(typeOn), .dataOut(dataOut)
  );
endmodule

// File: rtl/pattern_slave_chk.sv
module pattern_slave_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 10,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              startStb,
  input logic [CODE_W-1:0] nextCode,
  input logic [DATA_W-1:0] dataOut,
  input logic [CODE_W-1:0] curCode,
  input logic [ADDR_W-1:0] curOffset,
  input logic              started,
  input logic              typeOn
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> dataOut == '0);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (curOffset == '0) && (curCode == $past(nextCode)));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!startStb && started && typeOn && clkEn) |=>
      curOffset == ADDR_W'($past(curOffset) + 1'b1));

  assert_hold_offset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!startStb && !clkEn) |=> $stable(curOffset));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (started && !typeOn && !startStb) |=> $stable(dataOut) && $stable(curOffset));

  assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startStb && clkEn) |=> curOffset == '0);
endmodule

bind pattern_slave pattern_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .startStb(startStb), .nextCode(nextCode),
  .dataOut(dataOut), .curCode(curCode), .curOffset(curOffset), .started(started),
  .typeOn(typeOn)
);

// File: tb/pattern_slave_tb.sv
module pattern_slave_tb;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 10;
  localparam int CODE_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TYPES  = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEn = 1'b0;
  logic              startStb = 1'b0;
  logic [CODE_W-1:0] nextCode = '0;
  logic              runActive = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [1:0]        cfgKind = 2'd3;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [DATA_W-1:0] cfgData = '0;
  logic [DATA_W-1:0] dataOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] mTab [DEPTH];
  logic [ADDR_W-1:0] mBase [TYPES];
  bit                mMask [TYPES];
  logic [CODE_W-1:0] mCode = '0;
  logic [ADDR_W-1:0] mOff = '0;
  bit                mStarted = 1'b0;
  logic [DATA_W-1:0] mOut = '0;

  pattern_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .startStb(startStb), .nextCode(nextCode),
    .runActive(runActive), .cfgWrEn(cfgWrEn), .cfgKind(cfgKind), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .dataOut(dataOut)
  );

  always #4 clk = ~clk;

  function automatic logic [DATA_W-1:0] wordAt(input logic [CODE_W-1:0] c,
                                               input logic [ADDR_W-1:0] off);
    logic [ADDR_W-1:0] a;
    a = mBase[c] + off;
    return mTab[a];
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] exp);
    checks++;
    if (dataOut !== exp) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected=%h at %0t", tag, dataOut, exp, $time);
    end
  endtask

  // one clock cycle: drive at negedge, model the edge, return at next negedge
  task automatic step(input bit en, input bit st, input logic [CODE_W-1:0] code,
                      input bit wr, input logic [1:0] kind,
                      input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data,
                      input bit run);
    bit tOn;
    clkEn = en; startStb = st; nextCode = code;
    cfgWrEn = wr; cfgKind = kind; cfgAddr = addr; cfgData = data; runActive = run;
    @(posedge clk);
    tOn = mMask[mCode];
    if (mStarted && tOn) mOut = wordAt(mCode, mOff);
    if (st) begin
      mCode = code; mOff = '0; mStarted = 1'b1;
    end else if (mStarted && tOn && en) begin
      mOff = mOff + 1'b1;
    end
    if (wr && !run) begin
      case (kind)
        2'd0: mTab[addr] = data;
        2'd1: mBase[addr[CODE_W-1:0]] = data[ADDR_W-1:0];
        2'd2: mMask[addr[CODE_W-1:0]] = data[0];
        default: ;
      endcase
    end
    @(negedge clk);
    cfgWrEn = 1'b0; startStb = 1'b0;
  endtask

  task automatic idle(input bit en);
    step(en, 1'b0, '0, 1'b0, 2'd3, '0, '0, 1'b0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] oldWord;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < DEPTH; i++) mTab[i] = '0;
    for (int i = 0; i < TYPES; i++) begin mBase[i] = '0; mMask[i] = 1'b0; end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1", '0);
    step(1'b1, 1'b0, 8'd4, 1'b0, 2'd3, '0, '0, 1'b0);
    check("R1", '0);

    // load table, bases and masks
    for (int i = 0; i < DEPTH; i++)
      step(1'b0, 1'b0, '0, 1'b1, 2'd0, ADDR_W'(i), DATA_W'($urandom), 1'b0);
    for (int i = 0; i < TYPES; i++)
      step(1'b0, 1'b0, '0, 1'b1, 2'd1, ADDR_W'(i), DATA_W'($urandom_range(0, DEPTH-1)), 1'b0);
    for (int i = 0; i < TYPES; i++)
      step(1'b0, 1'b0, '0, 1'b1, 2'd2, ADDR_W'(i), DATA_W'((i % 3) != 0), 1'b0);
    step(1'b0, 1'b0, '0, 1'b1, 2'd1, ADDR_W'(7), DATA_W'(1022), 1'b0);
    check("R1", '0);

    // R2: start code 7, first word from base
    step(1'b0, 1'b1, 8'd7, 1'b0, 2'd3, '0, '0, 1'b0);
    idle(1'b0);
    check("R2", mTab[1022]);

    // R3 and R5: advance across the end of the table
    idle(1'b1); check("R3", mTab[1022]);
    idle(1'b1); check("R3", mTab[1023]);
    idle(1'b1); check("R5", mTab[0]);
    idle(1'b1); check("R5", mTab[1]);

    // R4: enable low repeats the word
    held = dataOut;
    repeat (3) begin idle(1'b0); check("R4", mTab[2]); end

    // R8: start collides with clkEn
    step(1'b1, 1'b1, 8'd7, 1'b0, 2'd3, '0, '0, 1'b0);
    idle(1'b1);
    check("R8", mTab[1022]);
    idle(1'b0);
    check("R8", mTab[1023]);

    // R6: disabled type 9 freezes output and offset
    held = dataOut;
    step(1'b1, 1'b1, 8'd9, 1'b0, 2'd3, '0, '0, 1'b0);
    check("R6", wordAt(8'd7, 10'd1));
    held = dataOut;
    repeat (5) begin idle(1'b1); check("R6", held); end
    step(1'b0, 1'b0, '0, 1'b1, 2'd2, ADDR_W'(9), DATA_W'(1), 1'b0);
    check("R6", held);
    idle(1'b0);
    check("R6", wordAt(8'd9, 10'd0));

    // R7: writes while running are dropped
    oldWord = mTab[1022];
    step(1'b0, 1'b0, '0, 1'b1, 2'd0, ADDR_W'(1022), ~oldWord, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1, 2'd1, ADDR_W'(7), DATA_W'(5), 1'b1);
    step(1'b0, 1'b0, '0, 1'b1, 2'd2, ADDR_W'(7), DATA_W'(0), 1'b1);
    step(1'b0, 1'b0, '0, 1'b1, 2'd3, ADDR_W'(7), DATA_W'(0), 1'b0);
    step(1'b0, 1'b1, 8'd7, 1'b0, 2'd3, '0, '0, 1'b0);
    idle(1'b0);
    check("R7", oldWord);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit en, st, wr, run;
      logic [1:0] kind;
      en   = ($urandom_range(0, 3) != 0);
      st   = ($urandom_range(0, 19) == 0);
      wr   = ($urandom_range(0, 9) == 0);
      run  = ($urandom_range(0, 1) == 0);
      kind = 2'($urandom_range(0, 3));
      step(en, st, CODE_W'($urandom), wr, kind, ADDR_W'($urandom), DATA_W'($urandom), run);
      check("R3", mOut);
    end

    finishRun();
  end
endmodule